// File: doc/BRIEF.md
# Pipeline Memory-Access Stage with Branch Resolution

This block is the fourth stage of a five-stage in-order integer pipeline. Each cycle it may take one completed packet from the execute stage. A packet carries an instruction word, a one-bit condition status and two data words. The stage routes the packet according to the class encoded in the instruction.

Arithmetic results pass straight on to write-back. Loads and stores issue one request to data memory and then block until memory replies. A load forwards the returned word to write-back. A store's reply is only an acknowledgement. Branches and jumps are resolved here: the stage computes the next program counter and sends it to fetch. Fetch uses it to reload its prefetch counter and to leave its held state.

The instruction word is split into fields. Bits [31:29] give the class. Bits [20:16] give the destination register. Bits [15:0] give the signed branch offset. Bits [28:0] give the absolute jump target. For a branch, data2 carries the branch's own instruction address. Addresses are counted in instructions.

Top module: `mem_access_stage`

## Requirements
- R1: After a synchronous active-low reset, `wb_valid`, `dm_req`, `redir_valid` and `ex_hold` are 0 and `redir_pc` is 0.
- R2: An accepted packet of class 3'b001 (arithmetic) gives, one cycle later, a single-cycle `wb_valid` with `wb_data` equal to data1 and `wb_reg` equal to instruction bits [20:16].
- R3: An accepted packet of class 3'b010 (load) gives, one cycle later, a single-cycle `dm_req` with `dm_we`=0 and `dm_addr` equal to data1. From that cycle, `ex_hold` stays 1 until the memory reply has been taken.
- R4: While a load is waiting, a `dm_rsp_valid` cycle gives, one cycle later, a single-cycle `wb_valid` with `wb_data` equal to the returned `dm_rdata` and `wb_reg` equal to the load's bits [20:16]. In that same later cycle `ex_hold` is 0.
- R5: An accepted packet of class 3'b011 (store) gives, one cycle later, `dm_req` with `dm_we`=1, `dm_addr` equal to data1 and `dm_wdata` equal to data2. `ex_hold` stays 1 until the reply. The reply then releases the hold and never raises `wb_valid`.
- R6: While `ex_hold` is 1, a packet offered by execute is ignored. It produces no `wb_valid`, `dm_req` or `redir_valid`, either then or after the hold drops.
- R7: An accepted packet of class 3'b100 (conditional branch) with `ex_cond_taken`=1 gives, one cycle later, a single-cycle `redir_valid`. `redir_pc` then equals data2 + 1 + the sign-extended offset in bits [15:0].
- R8: A class 3'b100 packet with `ex_cond_taken`=0 still gives `redir_valid` one cycle later. In that case `redir_pc` equals data2 + 1.
- R9: An accepted packet of class 3'b101 (jump) gives `redir_valid` one cycle later. `redir_pc` equals bits [28:0] zero-extended, whatever `ex_cond_taken` is.
- R10: A `dm_rsp_valid` pulse while no load or store is waiting has no effect on `wb_valid` or `ex_hold`.
- R11: A packet of class 3'b000 (no-op), or of any class value above 3'b101, produces no output activity.
- R12: In any cycle, at most one of `wb_valid`, `dm_req` and `redir_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ex_valid | input | 1 | Execute offers a packet |
| ex_instr | input | 32 | Instruction word of the packet |
| ex_cond_taken | input | 1 | Branch condition result from execute |
| ex_data1 | input | 32 | Result or memory address |
| ex_data2 | input | 32 | Store data or branch address |
| ex_hold | output | 1 | Stage busy; execute must keep its packet |
| dm_req | output | 1 | Data-memory request strobe |
| dm_we | output | 1 | Request is a write |
| dm_addr | output | 32 | Memory address |
| dm_wdata | output | 32 | Write data |
| dm_rsp_valid | input | 1 | Memory reply (load data or store acknowledge) |
| dm_rdata | input | 32 | Load data from memory |
| wb_valid | output | 1 | Write-back packet valid |
| wb_reg | output | 5 | Destination register |
| wb_data | output | 32 | Value to write |
| redir_valid | output | 1 | Program counter update to fetch |
| redir_pc | output | 32 | New program counter |

## Verification
The embedded assertions watch several rules on every cycle. The three output strobes are mutually exclusive. A memory request appears only while the stage is blocked. A blocked cycle with no reply lets nothing out. A reply to a pending load always produces write-back on the next cycle. The directed scenarios cover what the assertions cannot see: the actual data, register and address values, and the branch target arithmetic for taken, not-taken, backward and absolute cases. They also check that packets offered during a wait are dropped rather than replayed, and that store acknowledgements and stray replies stay silent.

// File: rtl/memstg_pkg.sv
// Package: shared instruction class type for the memory-access stage.
// Assumes the class sits in the top three bits of the instruction word.
package memstg_pkg;
    typedef enum logic [2:0] {
        K_NOP    = 3'd0,
        K_ALU    = 3'd1,
        K_LOAD   = 3'd2,
        K_STORE  = 3'd3,
        K_BRANCH = 3'd4,
        K_JUMP   = 3'd5
    } kind_e;

    localparam int KIND_W = 3;
endpackage

// File: rtl/memstg_decode.sv
// Field extractor: splits an instruction word into class, destination,
// branch offset and jump target. Unused class codes decode to no-op.
module memstg_decode
    import memstg_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int RD_W    = 5,
    parameter int OFF_W   = 16
) (
    input  logic [INSTR_W-1:0]        instr,
    output kind_e                     kind,
    output logic [RD_W-1:0]           rd,
    output logic [OFF_W-1:0]          off,
    output logic [INSTR_W-KIND_W-1:0] tgt
);
    localparam int RD_LSB = OFF_W;

    // Map class bits onto the enum, folding reserved codes to no-op.
    always_comb begin
        case (instr[INSTR_W-1 -: KIND_W])
            3'd1:    kind = K_ALU;
            3'd2:    kind = K_LOAD;
            3'd3:    kind = K_STORE;
            3'd4:    kind = K_BRANCH;
            3'd5:    kind = K_JUMP;
            default: kind = K_NOP;
        endcase
    end

    // Plain field slices.
    always_comb begin
        rd  = instr[RD_LSB +: RD_W];
        off = instr[OFF_W-1:0];
        tgt = instr[INSTR_W-KIND_W-1:0];
    end
endmodule

// File: rtl/memstg_target.sv
// Next-PC generator: picks among the absolute jump target, the taken
// relative target and the fall-through address. Offsets count instructions.
module memstg_target
    import memstg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16,
    parameter int TGT_W  = 29
) (
    input  kind_e              kind,
    input  logic               cond_taken,
    input  logic [DATA_W-1:0]  base_pc,
    input  logic [OFF_W-1:0]   off,
    input  logic [TGT_W-1:0]   tgt,
    output logic [DATA_W-1:0]  next_pc
);
    logic [DATA_W-1:0] seq_pc;
    logic [DATA_W-1:0] off_ext;

    // Fall-through address and sign-extended offset.
    always_comb begin
        seq_pc  = base_pc + DATA_W'(1);
        off_ext = {{(DATA_W-OFF_W){off[OFF_W-1]}}, off};
    end

    // Select the redirect address.
    always_comb begin
        if (kind == K_JUMP)
            next_pc = {{(DATA_W-TGT_W){1'b0}}, tgt};
        else if (cond_taken)
            next_pc = seq_pc + off_ext;
        else
            next_pc = seq_pc;
    end
endmodule

// File: rtl/memstg_seq.sv
// Wait sequencer: goes busy when a load or store request is issued and
// returns to idle on the memory reply. Remembers whether the pending
// access is a store, so that its reply makes no write-back.
module memstg_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic start_mem,
    input  logic start_is_store,
    input  logic rsp_valid,
    output logic busy,
    output logic pend_store,
    output logic rsp_take
);
    typedef enum logic {S_IDLE = 1'b0, S_WAIT = 1'b1} st_e;
    st_e state;

    // State update: enter wait on issue, leave on reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            pend_store <= 1'b0;
        end else if (state == S_IDLE && start_mem) begin
            state      <= S_WAIT;
            pend_store <= start_is_store;
        end else if (state == S_WAIT && rsp_valid) begin
            state      <= S_IDLE;
        end
    end

    // Status decode.
    always_comb begin
        busy     = (state == S_WAIT);
        rsp_take = busy && rsp_valid;
    end
endmodule

// File: rtl/mem_access_stage.sv
// Memory-access stage top: accepts execute packets when not waiting,
// forwards arithmetic results, issues memory accesses and blocks on their
// replies, and resolves branches and jumps into a redirect to fetch.
// Assumes execute holds its packet steady while ex_hold is high.
module mem_access_stage
    import memstg_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int INSTR_W = 32,
    parameter int RD_W    = 5,
    parameter int OFF_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ex_valid,
    input  logic [INSTR_W-1:0] ex_instr,
    input  logic               ex_cond_taken,
    input  logic [DATA_W-1:0]  ex_data1,
    input  logic [DATA_W-1:0]  ex_data2,
    output logic               ex_hold,
    output logic               dm_req,
    output logic               dm_we,
    output logic [DATA_W-1:0]  dm_addr,
    output logic [DATA_W-1:0]  dm_wdata,
    input  logic               dm_rsp_valid,
    input  logic [DATA_W-1:0]  dm_rdata,
    output logic               wb_valid,
    output logic [RD_W-1:0]    wb_reg,
    output logic [DATA_W-1:0]  wb_data,
    output logic               redir_valid,
    output logic [DATA_W-1:0]  redir_pc
);
    localparam int TGT_W = INSTR_W - KIND_W;

    kind_e             kind;
    logic [RD_W-1:0]   rd;
    logic [OFF_W-1:0]  off;
    logic [TGT_W-1:0]  tgt;
    logic [DATA_W-1:0] next_pc;
    logic              busy, pend_store, rsp_take;
    logic              accept, start_mem, start_is_store;

    memstg_decode #(.INSTR_W(INSTR_W), .RD_W(RD_W), .OFF_W(OFF_W)) u_dec (
        .instr (ex_instr),
        .kind  (kind),
        .rd    (rd),
        .off   (off),
        .tgt   (tgt)
    );

    memstg_target #(.DATA_W(DATA_W), .OFF_W(OFF_W), .TGT_W(TGT_W)) u_tgt (
        .kind       (kind),
        .cond_taken (ex_cond_taken),
        .base_pc    (ex_data2),
        .off        (off),
        .tgt        (tgt),
        .next_pc    (next_pc)
    );

    memstg_seq u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_mem      (start_mem),
        .start_is_store (start_is_store),
        .rsp_valid      (dm_rsp_valid),
        .busy           (busy),
        .pend_store     (pend_store),
        .rsp_take       (rsp_take)
    );

    // Acceptance and memory-start decode.
    always_comb begin
        accept         = ex_valid && !busy;
        start_mem      = accept && (kind == K_LOAD || kind == K_STORE);
        start_is_store = (kind == K_STORE);
        ex_hold        = busy;
    end

    // Output registers: one strobe per accepted packet or load reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid    <= 1'b0;
            wb_reg      <= '0;
            wb_data     <= '0;
            dm_req      <= 1'b0;
            dm_we       <= 1'b0;
            dm_addr     <= '0;
            dm_wdata    <= '0;
            redir_valid <= 1'b0;
            redir_pc    <= '0;
        end else begin
            wb_valid    <= 1'b0;
            dm_req      <= 1'b0;
            redir_valid <= 1'b0;
            if (accept) begin
                case (kind)
                    K_ALU: begin
                        wb_valid <= 1'b1;
                        wb_reg   <= rd;
                        wb_data  <= ex_data1;
                    end
                    K_LOAD: begin
                        dm_req  <= 1'b1;
                        dm_we   <= 1'b0;
                        dm_addr <= ex_data1;
                        wb_reg  <= rd;
                    end
                    K_STORE: begin
                        dm_req   <= 1'b1;
                        dm_we    <= 1'b1;
                        dm_addr  <= ex_data1;
                        dm_wdata <= ex_data2;
                    end
                    K_BRANCH, K_JUMP: begin
                        redir_valid <= 1'b1;
                        redir_pc    <= next_pc;
                    end
                    default: ;
                endcase
            end else if (rsp_take && !pend_store) begin
                wb_valid <= 1'b1;
                wb_data  <= dm_rdata;
            end
        end
    end

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_valid, dm_req, redir_valid}));

    // R3
    req_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dm_req |-> ex_hold);

    // R6
    quiet_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dm_rsp_valid) |=> (!wb_valid && !dm_req && !redir_valid));

    // R4
    load_reply_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dm_rsp_valid && !pend_store) |=> (wb_valid && !ex_hold));

    // R5
    store_ack_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dm_rsp_valid && pend_store) |=> !wb_valid);
endmodule

// File: tb/mem_access_stage_bench.sv
`timescale 1ns/1ps
module mem_access_stage_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ex_valid = 1'b0;
    logic [31:0] ex_instr = '0;
    logic        ex_cond_taken = 1'b0;
    logic [31:0] ex_data1 = '0;
    logic [31:0] ex_data2 = '0;
    logic        ex_hold;
    logic        dm_req, dm_we;
    logic [31:0] dm_addr, dm_wdata;
    logic        dm_rsp_valid = 1'b0;
    logic [31:0] dm_rdata = '0;
    logic        wb_valid;
    logic [4:0]  wb_reg;
    logic [31:0] wb_data;
    logic        redir_valid;
    logic [31:0] redir_pc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mem_access_stage u_mem_access_stage (
        .clk(clk), .rst_n(rst_n),
        .ex_valid(ex_valid), .ex_instr(ex_instr), .ex_cond_taken(ex_cond_taken),
        .ex_data1(ex_data1), .ex_data2(ex_data2), .ex_hold(ex_hold),
        .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
        .dm_rsp_valid(dm_rsp_valid), .dm_rdata(dm_rdata),
        .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data),
        .redir_valid(redir_valid), .redir_pc(redir_pc)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [2:0] k, input logic [4:0] rd,
                                       input logic [15:0] lo);
        return {k, 8'h00, rd, lo};
    endfunction

    // Offer one packet for one cycle; outputs are visible at return.
    task automatic offer(input logic [31:0] ins, input logic c,
                         input logic [31:0] d1, input logic [31:0] d2);
        @(negedge clk);
        ex_valid = 1'b1; ex_instr = ins; ex_cond_taken = c;
        ex_data1 = d1; ex_data2 = d2;
        @(negedge clk);
        ex_valid = 1'b0;
    endtask

    task automatic reply(input logic [31:0] data);
        @(negedge clk);
        dm_rsp_valid = 1'b1; dm_rdata = data;
        @(negedge clk);
        dm_rsp_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk({31'b0, wb_valid}, 0, "R1 wb_valid");
        chk({31'b0, dm_req}, 0, "R1 dm_req");
        chk({31'b0, redir_valid}, 0, "R1 redir_valid");
        chk({31'b0, ex_hold}, 0, "R1 ex_hold");
        chk(redir_pc, 0, "R1 redir_pc");
    endtask

    task automatic t_alu;
        offer(mk(3'b001, 5'd7, 16'h0), 1'b0, 32'hCAFE_0001, 32'h0);
        chk({31'b0, wb_valid}, 1, "R2 wb_valid");
        chk(wb_data, 32'hCAFE_0001, "R2 wb_data");
        chk({27'b0, wb_reg}, 7, "R2 wb_reg");
        chk({31'b0, dm_req | redir_valid}, 0, "R12 other strobes");
        @(negedge clk);
        chk({31'b0, wb_valid}, 0, "R2 single cycle");
    endtask

    task automatic t_load;
        offer(mk(3'b010, 5'd12, 16'h0), 1'b0, 32'h0000_0400, 32'h0);
        chk({31'b0, dm_req}, 1, "R3 dm_req");
        chk({31'b0, dm_we}, 0, "R3 dm_we");
        chk(dm_addr, 32'h400, "R3 dm_addr");
        chk({31'b0, ex_hold}, 1, "R3 ex_hold");
        // R6: packet offered while waiting is dropped
        @(negedge clk);
        chk({31'b0, dm_req}, 0, "R3 req single cycle");
        ex_valid = 1'b1; ex_instr = mk(3'b001, 5'd3, 16'h0); ex_data1 = 32'h55;
        @(negedge clk);
        chk({31'b0, wb_valid}, 0, "R6 no wb while waiting");
        chk({31'b0, ex_hold}, 1, "R3 hold kept");
        ex_valid = 1'b0;
        reply(32'hDEAD_BEEF);
        chk({31'b0, wb_valid}, 1, "R4 wb_valid");
        chk(wb_data, 32'hDEAD_BEEF, "R4 wb_data");
        chk({27'b0, wb_reg}, 12, "R4 wb_reg");
        chk({31'b0, ex_hold}, 0, "R4 hold released");
        @(negedge clk);
        chk({31'b0, wb_valid | dm_req | redir_valid}, 0, "R6 no replay");
    endtask

    task automatic t_store;
        offer(mk(3'b011, 5'd0, 16'h0), 1'b0, 32'h0000_0010, 32'h1234_5678);
        chk({31'b0, dm_req}, 1, "R5 dm_req");
        chk({31'b0, dm_we}, 1, "R5 dm_we");
        chk(dm_addr, 32'h10, "R5 dm_addr");
        chk(dm_wdata, 32'h1234_5678, "R5 dm_wdata");
        chk({31'b0, ex_hold}, 1, "R5 ex_hold");
        @(negedge clk);
        reply(32'h0);
        chk({31'b0, wb_valid}, 0, "R5 ack no wb");
        chk({31'b0, ex_hold}, 0, "R5 hold released");
    endtask

    task automatic t_branch;
        offer(mk(3'b100, 5'd0, 16'hFFFD), 1'b1, 32'h0, 32'd100);
        chk({31'b0, redir_valid}, 1, "R7 redir_valid");
        chk(redir_pc, 32'd98, "R7 backward taken");
        offer(mk(3'b100, 5'd0, 16'd5), 1'b1, 32'h0, 32'd0);
        chk(redir_pc, 32'd6, "R7 forward taken");
        offer(mk(3'b100, 5'd0, 16'd5), 1'b0, 32'h0, 32'd40);
        chk({31'b0, redir_valid}, 1, "R8 redir_valid");
        chk(redir_pc, 32'd41, "R8 not taken");
        offer({3'b101, 29'h0012_345}, 1'b0, 32'h0, 32'd77);
        chk({31'b0, redir_valid}, 1, "R9 redir_valid");
        chk(redir_pc, 32'h0012_345, "R9 jump target");
        @(negedge clk);
        chk({31'b0, redir_valid}, 0, "R7 single cycle");
    endtask

    task automatic t_quiet;
        reply(32'hFFFF_FFFF);
        chk({31'b0, wb_valid}, 0, "R10 stray reply wb");
        chk({31'b0, ex_hold}, 0, "R10 stray reply hold");
        offer(mk(3'b000, 5'd9, 16'h1), 1'b1, 32'h9, 32'h9);
        chk({31'b0, wb_valid | dm_req | redir_valid}, 0, "R11 no-op silent");
        offer(mk(3'b111, 5'd9, 16'h1), 1'b1, 32'h9, 32'h9);
        chk({31'b0, wb_valid | dm_req | redir_valid}, 0, "R11 reserved silent");
        chk(redir_pc, 32'h0012_345, "R11 redir_pc kept");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_alu();
        t_load();
        t_store();
        t_branch();
        t_quiet();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule